// File: doc/BRIEF.md
# Switch and LED Port Bank on an Isolated I/O Bus

This block sits on a processor's separate I/O address space and serves eight byte-wide port pairs. Each pair has one address. A read of that address places a byte from a group of external switches on the data bus. A write to the same address loads a byte into a register that drives a group of LEDs. Together the block provides 64 switch inputs and 64 registered LED outputs.

The full 16-bit I/O address is decoded. Only the eight consecutive addresses CBF0h to CBF7h respond, and only while the I/O-versus-memory qualifier is high. Reads are combinational: the data bus enable follows the active-low read strobe. Writes are synchronous to the system clock. While the write strobe is low, the block samples the address and the data. The LED byte is committed when the strobe's rising edge is detected. A program that reads a port and writes the same value back to the same address copies the switch settings onto the LEDs.

Top module: `iop_port_bank`

## Requirements
- R1: A port pair is selected only when `io_m` is 1 and `io_addr[15:3]` equals 13'b1100_1011_1111_0. This gives the addresses CBF0h to CBF7h. Bits [2:0] give the pair index k, so CBF4h selects pair 4.
- R2: While `rd_n` is 0 and a pair k is selected, `data_oe` is 1 and `data_out` equals `sw_in[8k+7:8k]` in the same cycle, with no clock involved.
- R3: While `rd_n` is 1, `data_oe` is 0.
- R4: An LED byte never changes while `wr_n` stays low. A write takes effect on the first rising clock edge at which `wr_n` is seen high after being low.
- R5: The byte written, and the pair it goes to, are those present on `data_in` and `io_addr` at the last rising clock edge during which `wr_n` was low. Later changes on the bus have no effect on that write.
- R6: An access with `io_m` = 0, or with an address outside CBF0h to CBF7h, leaves `data_oe` at 0 and leaves all 64 LED outputs unchanged.
- R7: While `rst_n` is 0, all LED outputs are 0.
- R8: A write changes at most the one LED byte `led_out[8k+7:8k]` of the selected pair. A 1 bit lights its LED.
- R9: Reading pair k and writing the returned byte back to the same address makes `led_out[8k+7:8k]` equal `sw_in[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_m | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| data_in | input | 8 | Data bus from the processor |
| data_out | output | 8 | Data bus toward the processor |
| data_oe | output | 1 | Enable for driving data_out onto the bus |
| sw_in | input | 64 | Switch inputs, byte k belongs to pair k |
| led_out | output | 64 | LED outputs, byte k belongs to pair k |

## Verification
Faults on the read path show up at once, in the same cycle as the strobe. A wrong decode or mux shows as a wrong byte, or as an enable asserted for a foreign address. A faulty write path shows one clock after the strobe rises, as a wrong LED byte, a wrong pair updated, or a byte that moves while the strobe is still low. A fault can also hide in a register that is rarely written. The random mix therefore revisits every pair many times and compares all 64 LED bits after every write, so such a fault surfaces at the next write to any pair.

// File: rtl/iop_pkg.sv
package iop_pkg;
  parameter int unsigned ADDR_W  = 16;
  parameter int unsigned BYTE_W  = 8;
  parameter int unsigned N_PAIRS = 8;

  localparam int unsigned SEL_W = $clog2(N_PAIRS);
  localparam int unsigned BUS_W = BYTE_W * N_PAIRS;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [SEL_W-1:0]   sel_t;
  typedef logic [N_PAIRS-1:0] strb_t;
  typedef logic [BUS_W-1:0]   bus_t;

  // upper address bits compared against the fixed window
  function automatic logic window_match(addr_t a, addr_t base);
    return a[ADDR_W-1:SEL_W] == base[ADDR_W-1:SEL_W];
  endfunction

  function automatic sel_t pair_index(addr_t a);
    return a[SEL_W-1:0];
  endfunction

  // active-low one-hot strobe, all high when disabled
  function automatic strb_t strobe_n(sel_t s, logic en);
    strb_t r;
    r = '1;
    if (en) r[s] = 1'b0;
    return r;
  endfunction

  function automatic byte_t byte_of(bus_t b, sel_t s);
    return b[s*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/iop_decode.sv
module iop_decode
  import iop_pkg::*;
#(
  parameter addr_t BASE_ADDR = 16'hCBF0
) (
  input  addr_t io_addr,
  input  logic  io_m,
  output logic  hit,
  output sel_t  sel,
  output strb_t sel_n
);
  always_comb begin
    hit   = io_m && window_match(io_addr, BASE_ADDR);
    sel   = pair_index(io_addr);
    sel_n = strobe_n(sel, hit);
  end
endmodule

// File: rtl/iop_read_path.sv
module iop_read_path
  import iop_pkg::*;
(
  input  logic  rd_n,
  input  logic  hit,
  input  strb_t sel_n,
  input  bus_t  sw_bus,
  output byte_t data_out,
  output logic  data_oe
);
  byte_t gated [N_PAIRS];

  for (genvar k = 0; k < N_PAIRS; k++) begin : g_gate
    assign gated[k] = (!sel_n[k] && !rd_n) ? sw_bus[k*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    data_out = '0;
    for (int k = 0; k < N_PAIRS; k++) data_out |= gated[k];
    data_oe = hit && !rd_n;
  end
endmodule

// File: rtl/iop_write_capture.sv
module iop_write_capture
  import iop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_n,
  input  logic  hit,
  input  sel_t  sel,
  input  byte_t data_in,
  output logic  wr_rise,
  output logic  commit,
  output sel_t  commit_sel,
  output byte_t commit_data
);
  logic  wr_n_q;
  logic  cap_hit;
  sel_t  cap_sel;
  byte_t cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q   <= 1'b1;
      cap_hit  <= 1'b0;
      cap_sel  <= '0;
      cap_data <= '0;
    end else begin
      wr_n_q <= wr_n;
      if (!wr_n) begin
        cap_hit  <= hit;
        cap_sel  <= sel;
        cap_data <= data_in;
      end
    end
  end

  always_comb begin
    wr_rise     = wr_n && !wr_n_q;
    commit      = wr_rise && cap_hit;
    commit_sel  = cap_sel;
    commit_data = cap_data;
  end
endmodule

// File: rtl/iop_led_bank.sv
module iop_led_bank
  import iop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  commit,
  input  sel_t  commit_sel,
  input  byte_t commit_data,
  output bus_t  led_out
);
  strb_t load;
  assign load = ~strobe_n(commit_sel, commit);

  for (genvar k = 0; k < N_PAIRS; k++) begin : g_byte
    byte_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (load[k]) q <= commit_data;
    end
    assign led_out[k*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/iop_port_bank.sv
module iop_port_bank
  import iop_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'hCBF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_m,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [7:0]  data_in,
  output logic [7:0]  data_out,
  output logic        data_oe,
  input  logic [63:0] sw_in,
  output logic [63:0] led_out
);
  logic  hit;
  sel_t  sel;
  strb_t sel_n;
  logic  wr_rise;
  logic  commit;
  sel_t  commit_sel;
  byte_t commit_data;

  iop_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
    .io_addr(io_addr), .io_m(io_m), .hit(hit), .sel(sel), .sel_n(sel_n)
  );

  iop_read_path u_rd (
    .rd_n(rd_n), .hit(hit), .sel_n(sel_n), .sw_bus(sw_in),
    .data_out(data_out), .data_oe(data_oe)
  );

  iop_write_capture u_wr (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .hit(hit), .sel(sel),
    .data_in(data_in), .wr_rise(wr_rise), .commit(commit),
    .commit_sel(commit_sel), .commit_data(commit_data)
  );

  iop_led_bank u_led (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_sel(commit_sel),
    .commit_data(commit_data), .led_out(led_out)
  );
endmodule

// File: rtl/iop_port_bank_chk.sv
module iop_port_bank_chk #(
  parameter logic [15:0] BASE_ADDR = 16'hCBF0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_m,
  input logic        rd_n,
  input logic [7:0]  data_out,
  input logic        data_oe,
  input logic [63:0] sw_in,
  input logic [63:0] led_out,
  input logic        wr_rise
);
  logic        in_win;
  logic [15:0] offs;
  logic [63:0] led_prev;
  logic [7:0]  chg;

  assign offs   = io_addr - BASE_ADDR;
  assign in_win = io_m && (io_addr >= BASE_ADDR) && (offs < 16'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_prev <= '0;
    else        led_prev <= led_out;
  end

  for (genvar k = 0; k < 8; k++) begin : g_chg
    assign chg[k] = led_prev[k*8 +: 8] != led_out[k*8 +: 8];
  end

  p_oe_needs_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !rd_n);

  p_oe_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> in_win);

  p_read_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && in_win) |-> (data_oe && data_out == sw_in[offs[2:0]*8 +: 8]));

  p_hold_without_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> $stable(led_out));

  p_single_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |=> led_out == 64'd0);
endmodule

bind iop_port_bank iop_port_bank_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_m(io_m), .rd_n(rd_n),
  .data_out(data_out), .data_oe(data_oe), .sw_in(sw_in),
  .led_out(led_out), .wr_rise(wr_rise)
);

// File: tb/iop_port_bank_test.sv
module iop_port_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_m = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  data_in = '0;
  logic [7:0]  data_out;
  logic        data_oe;
  logic [63:0] sw_in = '0;
  logic [63:0] led_out;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  logic [63:0] led_model = '0;

  always #2 clk = ~clk;

  iop_port_bank uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_m(io_m), .rd_n(rd_n),
    .wr_n(wr_n), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .sw_in(sw_in), .led_out(led_out)
  );

  function automatic bit responds(logic [15:0] a, logic m);
    return m && (a >= 16'hCBF0) && (a <= 16'hCBF7);
  endfunction

  function automatic logic [7:0] pick(logic [63:0] v, logic [15:0] a);
    int k;
    k = int'(a) - 'hCBF0;
    return v[k*8 +: 8];
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [15:0] a, logic m, logic [63:0] sw, output logic [7:0] got);
    @(negedge clk);
    io_addr = a; io_m = m; sw_in = sw; rd_n = 1'b0;
    #1;
    got = data_out;
    if (responds(a, m)) begin
      check(data_oe === 1'b1, "R2 oe", {63'd0, data_oe}, 64'd1);
      check(data_out === pick(sw, a), "R2 data", {56'd0, data_out}, {56'd0, pick(sw, a)});
    end else begin
      check(data_oe === 1'b0, "R6/R1 oe outside", {63'd0, data_oe}, 64'd0);
    end
    @(negedge clk);
    rd_n = 1'b1;
    #1;
    check(data_oe === 1'b0, "R3 release", {63'd0, data_oe}, 64'd0);
  endtask

  task automatic do_write(logic [15:0] a, logic m, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_m = m; data_in = d; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(led_out === led_model, "R4 stable while low", led_out, led_model);
    wr_n = 1'b1;
    io_addr = 16'hCBF0 + 16'(($urandom % 8));
    io_m = 1'b1;
    data_in = ~d;
    if (responds(a, m)) led_model[(int'(a) - 'hCBF0)*8 +: 8] = d;
    @(negedge clk);
    check(led_out === led_model,
          responds(a, m) ? "R5/R8 committed byte" : "R6 ignored write",
          led_out, led_model);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(led_out === 64'd0, "R7 reset leds", led_out, 64'd0);
    check(data_oe === 1'b0, "R3 reset oe", {63'd0, data_oe}, 64'd0);
    rst_n = 1'b1;

    // directed: window edges and qualifier (R1, R6)
    do_read(16'hCBF0, 1'b1, 64'h0123_4567_89AB_CDEF, rb);
    do_read(16'hCBF7, 1'b1, 64'h0123_4567_89AB_CDEF, rb);
    do_read(16'hCBEF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, rb);
    do_read(16'hCBF8, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, rb);
    do_read(16'hCBF4, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, rb);
    do_write(16'hCBF4, 1'b1, 8'hA5);
    do_write(16'hCBF8, 1'b1, 8'h3C);
    do_write(16'h4BF3, 1'b1, 8'h3C);
    do_write(16'hCBF3, 1'b0, 8'h3C);
    do_write(16'hCBF0, 1'b1, 8'hFF);
    do_write(16'hCBF7, 1'b1, 8'h81);

    // R9 mirror switches onto LEDs
    do_read(16'hCBF5, 1'b1, 64'h0000_5A00_0000_0000, rb);
    do_write(16'hCBF5, 1'b1, rb);
    check(led_out[47:40] === 8'h5A, "R9 mirror", {56'd0, led_out[47:40]}, 64'h5A);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic        m;
      a = ($urandom % 4 != 0) ? 16'hCBF0 + 16'($urandom % 8) : 16'($urandom);
      m = ($urandom % 5 != 0);
      if ($urandom % 2) do_read(a, m, {$urandom, $urandom}, rb);
      else              do_write(a, m, 8'($urandom));
    end

    // R7 reset mid-run clears LEDs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    led_model = '0;
    check(led_out === 64'd0, "R7 async clear", led_out, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule